// File: doc/BRIEF.md
# I2C Register Access Slave

This block is the serial front end of an eight-bit port expander. It runs on a fast system clock and oversamples the two-wire bus lines. Each line passes through a two-stage synchronizer and a filter that needs two equal samples in a row before it accepts a new level. From the filtered lines the block finds start, repeated start and stop conditions. It compares the 7-bit address against a fixed upper part and two strap inputs, and it acknowledges when the address matches. It then reads or writes a small register file held next to it.

A write transaction carries a command byte, which sets a register pointer. Any data bytes that follow are all written to that one register, because the pointer never advances. The pointer keeps its value across stop conditions, so a later transaction that only reads uses the last command that was written. A read streams the selected register, fetched again for each byte, until the master answers with a NACK.

The register file connects through one port. `reg_sel` always shows the pointer. A write goes out as a one-cycle `wr_valid` strobe with `wr_data`. A read byte is taken from `rd_data` in the cycle that `rd_fetch` pulses. There is no ready signal in either direction. The bus cannot be held, because clock stretching is not supported, so the register file must accept every strobe and keep `rd_data` valid combinationally for the current `reg_sel`.

Top module: `i2cs_regport`

## Requirements
- R1: The slave responds to address bits {1,1,1,0,0,strap[1],strap[0]}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). It acknowledges a matching address by pulling SDA low during the ninth clock.
- R2: After an address that does not match, the slave releases SDA and ignores the bus until the next start or stop. It gives no acknowledge and makes no register write.
- R3: The first byte after a write address is the command byte. The slave acknowledges it, and from then on `reg_sel` carries the low two bits of the command.
- R4: Each data byte after the command is acknowledged and produces exactly one `wr_valid` strobe. Every such strobe targets the same register, because the pointer does not increment.
- R5: The pointer survives a stop condition. A transaction that only reads uses the last command byte written.
- R6: In a read, each byte is fetched with one `rd_fetch` pulse and sent MSB first. Streaming continues while the master acknowledges. After a NACK the slave keeps SDA released until the next start or stop.
- R7: A command value above 3 is acknowledged. Data written after it produces no strobe, and reads after it return 0x00.
- R8: While `rst_n` is low, the slave is idle with SDA released, and the pointer returns to 0. A byte sent after reset without a new start is not acknowledged.
- R9: A pulse on SCL or SDA that lasts one system clock is ignored. It neither shifts a bit nor creates a start or stop condition.
- R10: A stop condition is accepted at any byte boundary. A stop that comes right after the command byte sets the pointer and writes nothing.
- R11: The slave changes SDA only while the filtered SCL is low. The `wr_valid` strobe lasts one cycle, comes at the falling SCL edge that begins the acknowledge clock, and never falls while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset; holds the slave idle |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (resolved bus) |
| strap | input | 2 | Low two address bits |
| sda_oe | output | 1 | When 1, pull SDA low (open drain) |
| reg_sel | output | 2 | Current register pointer, low bits |
| wr_valid | output | 1 | One-cycle write strobe to the register file |
| wr_data | output | 8 | Byte written with `wr_valid` |
| rd_fetch | output | 1 | One-cycle pulse: `rd_data` is taken for the next read byte |
| rd_data | input | 8 | Content of the register selected by `reg_sel` |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except when it makes a start or stop condition. They also assume that no bus edge is closer than a few system clocks to another edge on the other line. Otherwise the filtered lines could reorder events, and a well-behaved slave could appear to drive SDA while SCL is high. The bench master keeps every bus phase 20 system clocks long. It moves SDA only in the middle of an SCL low phase, and it uses single-cycle pulses only in the filter test. Those pulses are too short for the filter to pass, so the assumptions still hold at the filtered lines.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WDAT,
    S_ACK,
    S_TX,
    S_TXACK,
    S_SKIP
  } i2cs_st_e;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int  SYNC_N  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic filt,
  output logic rise,
  output logic fall
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              synced;

  assign synced = sync_q[SYNC_N-1];

  generate
    if (SYNC_N == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= RST_VAL;
        else        sync_q <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_N{RST_VAL}};
        else        sync_q <= {sync_q[SYNC_N-2:0], line_i};
      end
    end
  endgenerate

  // accept a level only after two equal samples in a row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
      filt   <= RST_VAL;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else begin
      prev_q <= synced;
      rise   <= 1'b0;
      fall   <= 1'b0;
      if (synced == prev_q && synced != filt) begin
        filt <= synced;
        rise <= synced;
        fall <= ~synced;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic scl_f,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  // filtered edges are one-cycle pulses; SDA moving while SCL is high
  assign start_det = sda_fall & scl_f;
  assign stop_det  = sda_rise & scl_f;
endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          NREG    = 4,
  parameter int          STRAP_W = 2,
  parameter logic [6-STRAP_W:0] ADDR_HI = 5'b11100,
  localparam int         PW      = $clog2(NREG),
  localparam int         BW      = $clog2(DW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_f,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DW-1:0]      rd_data,
  output logic               sda_oe,
  output logic [PW-1:0]      reg_sel,
  output logic               wr_valid,
  output logic [DW-1:0]      wr_data,
  output logic               rd_fetch,
  output logic               dormant
);
  i2cs_st_e          st, ack_nxt;
  logic [BW-1:0]     bitcnt;
  logic [DW-1:0]     shreg, txsh, ptr;
  logic [1:0]        ack_ph;
  logic              pend_wr, mack;
  logic [DW-1:0]     nb, tx_val;
  logic              ptr_ok;

  assign nb      = {shreg[DW-2:0], sda_f};
  assign ptr_ok  = (ptr < DW'(NREG));
  assign tx_val  = ptr_ok ? rd_data : '0;
  assign reg_sel = ptr[PW-1:0];
  assign dormant = (st == S_IDLE) || (st == S_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ack_nxt  <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      ack_ph   <= '0;
      pend_wr  <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_fetch <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_fetch <= 1'b0;
      if (stop_det) begin
        st      <= S_IDLE;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
      end else if (start_det) begin
        st      <= S_ADDR;
        bitcnt  <= '0;
        ack_ph  <= '0;
        sda_oe  <= 1'b0;
        pend_wr <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise) begin
              shreg  <= nb;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BW'(DW - 1)) begin
                ack_ph <= '0;
                if (st == S_ADDR) begin
                  if (nb[DW-1:1] == {ADDR_HI, strap}) begin
                    st      <= S_ACK;
                    ack_nxt <= nb[0] ? S_TX : S_CMD;
                  end else begin
                    st <= S_SKIP;
                  end
                end else if (st == S_CMD) begin
                  ptr     <= nb;
                  st      <= S_ACK;
                  ack_nxt <= S_WDAT;
                end else begin
                  wr_data <= nb;
                  pend_wr <= 1'b1;
                  st      <= S_ACK;
                  ack_nxt <= S_WDAT;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (ack_ph == 2'd0) begin
                ack_ph  <= 2'd1;
                sda_oe  <= 1'b1;
                pend_wr <= 1'b0;
                if (pend_wr && ptr_ok) wr_valid <= 1'b1;
              end else begin
                ack_ph <= '0;
                bitcnt <= '0;
                st     <= ack_nxt;
                if (ack_nxt == S_TX) begin
                  txsh     <= tx_val;
                  rd_fetch <= 1'b1;
                  sda_oe   <= ~tx_val[DW-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BW'(DW - 1)) begin
                st     <= S_TXACK;
                ack_ph <= '0;
              end
            end
            if (scl_fall) begin
              txsh   <= {txsh[DW-2:0], 1'b0};
              sda_oe <= ~txsh[DW-2];
            end
          end
          S_TXACK: begin
            if (ack_ph == 2'd0 && scl_fall) begin
              sda_oe <= 1'b0;
              ack_ph <= 2'd1;
            end else if (ack_ph == 2'd1 && scl_rise) begin
              mack   <= ~sda_f;
              ack_ph <= 2'd2;
            end else if (ack_ph == 2'd2 && scl_fall) begin
              ack_ph <= '0;
              bitcnt <= '0;
              if (mack) begin
                st       <= S_TX;
                txsh     <= tx_val;
                rd_fetch <= 1'b1;
                sda_oe   <= ~tx_val[DW-1];
              end else begin
                st <= S_SKIP;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport #(
  parameter int DW     = 8,
  parameter int NREG   = 4,
  parameter int SYNC_N = 2,
  localparam int PW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap,
  output logic          sda_oe,
  output logic [PW-1:0] reg_sel,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          rd_fetch,
  input  logic [DW-1:0] rd_data
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, filt, rise, fall;
  logic scl_filt, sda_filt, start_det, stop_det, dormant;

  assign raw      = {sda_i, scl_i};
  assign scl_filt = filt[0];
  assign sda_filt = filt[1];

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    i2cs_line_filter #(.SYNC_N(SYNC_N), .RST_VAL(1'b1)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw[g]),
      .filt  (filt[g]),
      .rise  (rise[g]),
      .fall  (fall[g])
    );
  end

  i2cs_bus_events u_ev (
    .scl_f    (scl_filt),
    .sda_rise (rise[1]),
    .sda_fall (fall[1]),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_xfer_fsm #(.DW(DW), .NREG(NREG), .STRAP_W(2), .ADDR_HI(5'b11100)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (rise[0]),
    .scl_fall (fall[0]),
    .sda_f    (sda_filt),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (strap),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .reg_sel  (reg_sel),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_fetch (rd_fetch),
    .dormant  (dormant)
  );
endmodule

// File: rtl/i2cs_regport_chk.sv
module i2cs_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_filt,
  input logic sda_oe,
  input logic wr_valid,
  input logic rd_fetch,
  input logic dormant
);
  // R11
  sda_move_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_filt);

  // R11
  wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R11
  wr_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !scl_filt);

  // R6
  fetch_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fetch |=> !rd_fetch);

  // R2
  dormant_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dormant |-> !sda_oe);

  // R2
  dormant_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dormant) && dormant |-> !wr_valid);
endmodule

bind i2cs_regport i2cs_regport_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_filt(scl_filt),
  .sda_oe  (sda_oe),
  .wr_valid(wr_valid),
  .rd_fetch(rd_fetch),
  .dormant (dormant)
);

// File: tb/test_i2cs_regport.sv
`timescale 1ns/1ps
module test_i2cs_regport;
  localparam int Q = 20;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic [1:0] strap;
  logic sda_oe, wr_valid, rd_fetch;
  logic [1:0] reg_sel;
  logic [7:0] wr_data, rd_data;
  wire sda_bus = m_sda & ~sda_oe;

  i2cs_regport i_i2cs_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap(strap),
    .sda_oe(sda_oe), .reg_sel(reg_sel), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_fetch(rd_fetch), .rd_data(rd_data)
  );

  // register file environment
  logic [7:0] regs [4];
  assign rd_data = regs[reg_sel];

  int total = 0, bad = 0, fetches = 0;
  bit done = 0;
  logic [9:0] exp_q [$];
  logic [7:0] shadow [4];
  logic [7:0] ptr_m;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rd_fetch) fetches++;
    if (wr_valid) begin
      regs[reg_sel] <= wr_data;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4: actual=%0h expected=none (unexpected write)", {reg_sel, wr_data});
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (e != {reg_sel, wr_data}) begin
          bad++;
          $display("FAIL R4: actual=%0h expected=%0h", {reg_sel, wr_data}, e);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1; wq(Q); m_scl = 1; wq(Q); m_sda = 0; wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wq(Q); m_scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      if (glitch && i == 4) begin m_scl = 1; wq(1); m_scl = 0; wq(Q); end
      m_scl = 1; wq(Q);
      if (glitch && i == 2 && b[i]) begin m_sda = 0; wq(1); m_sda = 1; end
      wq(Q); m_scl = 0; wq(Q);
    end
    m_sda = 1; wq(Q); m_scl = 1; wq(Q);
    ack = (sda_bus == 1'b0);
    wq(Q); m_scl = 0; wq(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 0; wq(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q); m_scl = 1; wq(2*Q); m_scl = 0; wq(Q);
    m_sda = 1;
  endtask

  // driver helpers: push expected writes
  task automatic set_cmd(input logic [7:0] c);
    ptr_m = c;
  endtask

  task automatic data_wr(input logic [7:0] d, input string tag, input bit glitch);
    bit a;
    if (ptr_m < 4) begin
      exp_q.push_back({ptr_m[1:0], d});
      shadow[ptr_m[1:0]] = d;
    end
    wr_byte(d, glitch, a);
    chk(a, tag, a, 1);
  endtask

  function automatic logic [7:0] exp_rd();
    return (ptr_m < 4) ? shadow[ptr_m[1:0]] : 8'h00;
  endfunction

  localparam logic [7:0] AW = 8'hE4, AR = 8'hE5; // strap = 2'b10

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    int f0;
    regs[0] = 8'h5A; regs[1] = 8'hFF; regs[2] = 8'h00; regs[3] = 8'h96;
    shadow[0] = 8'h5A; shadow[1] = 8'hFF; shadow[2] = 8'h00; shadow[3] = 8'h96;
    ptr_m = 0;
    m_scl = 1; m_sda = 1; strap = 2'b10; rst_n = 0;
    wq(10);
    // R8 reset state
    chk(sda_oe == 0 && wr_valid == 0 && rd_fetch == 0, "R8 reset outputs", sda_oe, 0);
    chk(reg_sel == 0, "R8 reset pointer", reg_sel, 0);
    rst_n = 1; wq(10);

    // R2 address mismatch
    i2c_start(); wr_byte(8'hE0, 0, a); chk(!a, "R2 mismatch no ack", a, 0);
    wr_byte(8'h01, 0, a); chk(!a, "R2 ignored byte no ack", a, 0);
    chk(sda_oe == 0, "R2 released", sda_oe, 0);
    i2c_stop();

    // R1 R3 R4 write cmd 1, two data bytes, no auto-increment
    i2c_start(); wr_byte(AW, 0, a); chk(a, "R1 address ack", a, 1);
    set_cmd(8'h01); wr_byte(8'h01, 0, a); chk(a, "R3 command ack", a, 1);
    chk(reg_sel == 2'd1, "R3 reg_sel", reg_sel, 1);
    data_wr(8'h3C, "R4 data ack 1", 0);
    data_wr(8'hC3, "R4 data ack 2", 0);
    chk(reg_sel == 2'd1, "R4 no increment", reg_sel, 1);
    i2c_stop();

    // R5 R6 read-only transaction, pointer kept
    f0 = fetches;
    i2c_start(); wr_byte(AR, 0, a); chk(a, "R5 read address ack", a, 1);
    rd_byte(1, b); chk(b == exp_rd(), "R5 read byte 1", b, exp_rd());
    rd_byte(0, b); chk(b == exp_rd(), "R6 read byte 2 same reg", b, exp_rd());
    wq(Q); chk(sda_oe == 0, "R6 released after NACK", sda_oe, 0);
    i2c_stop();
    chk(fetches - f0 == 2, "R6 fetch count", fetches - f0, 2);

    // R6 write cmd then repeated start read
    i2c_start(); wr_byte(AW, 0, a); set_cmd(8'h02); wr_byte(8'h02, 0, a);
    data_wr(8'h81, "R4 data to reg2", 0);
    i2c_start(); wr_byte(AR, 0, a); chk(a, "R6 rstart address ack", a, 1);
    rd_byte(1, b); chk(b == 8'h81, "R6 rstart read", b, 8'h81);
    rd_byte(1, b); chk(b == 8'h81, "R6 stream read", b, 8'h81);
    rd_byte(0, b); chk(b == 8'h81, "R6 last read", b, 8'h81);
    i2c_stop();

    // R7 out-of-range command
    i2c_start(); wr_byte(AW, 0, a); set_cmd(8'h07); wr_byte(8'h07, 0, a);
    chk(a, "R7 command ack", a, 1);
    data_wr(8'h55, "R7 data ack", 0);
    i2c_start(); wr_byte(AR, 0, a);
    rd_byte(0, b); chk(b == 8'h00, "R7 read zero", b, 0);
    i2c_stop();

    // R10 stop right after command
    i2c_start(); wr_byte(AW, 0, a); set_cmd(8'h03); wr_byte(8'h03, 0, a); i2c_stop();
    i2c_start(); wr_byte(AR, 0, a);
    rd_byte(0, b); chk(b == 8'h96, "R10 stop after command", b, 8'h96);
    i2c_stop();

    // R9 glitches on SCL and SDA
    i2c_start(); wr_byte(AW, 0, a); set_cmd(8'h00); wr_byte(8'h00, 0, a);
    data_wr(8'hA5, "R9 glitched byte ack", 1);
    i2c_stop();
    i2c_start(); wr_byte(AR, 0, a);
    rd_byte(0, b); chk(b == 8'hA5, "R9 glitched byte value", b, 8'hA5);
    i2c_stop();

    // R1 other strap
    strap = 2'b01;
    i2c_start(); wr_byte(8'hE2, 0, a); chk(a, "R1 strap 01 ack", a, 1); i2c_stop();
    i2c_start(); wr_byte(AW, 0, a); chk(!a, "R1 old address rejected", a, 0); i2c_stop();
    strap = 2'b10;

    // R8 reset mid-transaction
    i2c_start(); wr_byte(AW, 0, a); set_cmd(8'h01); wr_byte(8'h01, 0, a);
    rst_n = 0; wq(5);
    chk(sda_oe == 0, "R8 released in reset", sda_oe, 0);
    chk(reg_sel == 0, "R8 pointer cleared", reg_sel, 0);
    rst_n = 1; wq(5);
    ptr_m = 0;
    wr_byte(8'h77, 0, a); chk(!a, "R8 no ack after reset", a, 0);
    i2c_stop();
    i2c_start(); wr_byte(AR, 0, a);
    rd_byte(0, b); chk(b == exp_rd(), "R8 read pointer 0", b, exp_rd());
    i2c_stop();

    wq(20);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule